// File: doc/BRIEF.md
# Stem Cell Configuration Stream Parser

This block is the configuration front end of a reconfigurable logic cell that is currently in the stem state. Configuration arrives one bit at a time from a single upstream source over a valid/ready handshake. The parser reads a 3-bit header, most significant bit first, and acts on its value in one of three ways.

- A header of 1 to 6 names one of the six neighbour faces. That neighbour is turned into a stem cell, and every later input bit is tunnelled to it unchanged until it raises its done signal.
- A header of 7 introduces a 15-bit record that sets the cell's own gate type, its two input faces and its six-bit output-face mask.
- A header of 0 ends the stream. The cell then reports done to its upstream source and accepts nothing more.

Because each neighbour runs the same parser, a single stream can configure a whole chain or tree of cells. Each cell's own configuration is committed as one atomic update once its record is complete.

Top module: `stem_cfg_parser`

## Requirements
- R1: After synchronous reset, in_ready is 1, up_done is 0, cfg_valid is 0, all configuration outputs are 0, fwd_dir is 0 and fwd_valid is 0.
- R2: A header is 3 bits, sent most significant bit first. A header value from 1 to 6 appears on fwd_dir in the cycle after its last bit is accepted, and stays there until the neighbour reports done.
- R3: While forwarding, fwd_valid follows in_valid, fwd_bit follows in_bit, and in_ready follows fwd_ready. Every accepted bit therefore reaches the neighbour exactly once and in order, and a stalled neighbour stalls the input.
- R4: In a forwarding cycle where nbr_done is 1, no bit moves (in_ready and fwd_valid are both 0). From the next cycle fwd_dir is 0, and the next accepted bits form a new header.
- R5: Header 7 is followed by a 15-bit record, sent most significant bit first. Bits 14..12 are the type, 11..9 are input face A, 8..6 are input face B, and 5..0 are the output mask. All four fields and cfg_valid=1 appear together in the cycle after the last record bit, and the fields never show a partial record.
- R6: Header 0 raises up_done in the cycle after its last bit is accepted. up_done then stays 1, in_ready stays 0, and no output changes until reset.
- R7: A cycle with in_valid low consumes nothing and keeps the parse position, including in the middle of a header or record.
- R8: nbr_done is ignored when the parser is not forwarding.
- R9: A later own-configuration record replaces all fields of an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream bit is present |
| in_bit | input | 1 | Upstream stream bit |
| in_ready | output | 1 | Parser accepts the bit this cycle |
| fwd_dir | output | 3 | Neighbour face being configured, 0 when not forwarding |
| fwd_valid | output | 1 | Bit offered to the neighbour |
| fwd_bit | output | 1 | Bit offered to the neighbour |
| fwd_ready | input | 1 | Neighbour accepts the offered bit |
| nbr_done | input | 1 | Neighbour reports that its stream has ended |
| up_done | output | 1 | This cell's stream has ended (sticky) |
| cfg_valid | output | 1 | A configuration record has been committed |
| cfg_type | output | 3 | Gate type code |
| cfg_in_a | output | 3 | Face feeding input A |
| cfg_in_b | output | 3 | Face feeding input B |
| cfg_out_mask | output | 6 | One bit per face that receives the output |

## Verification
Two events can land in the same cycle: a bit being offered for forwarding and the neighbour raising done. The bench provokes this by ending each forwarded segment with the input held continuously valid and the neighbour always ready, so done arrives while the next header bit is already on in_bit. A behavioural model in the bench expects that bit to be withheld from the neighbour and parsed as header, and every output is compared against the model each cycle. A second pass throttles in_valid and fwd_ready at random and raises nbr_done outside forwarding, so that stalls, bubbles in the middle of a field and ignored done pulses are judged by the same model.

// File: rtl/stem_cfg_pkg.sv
package stem_cfg_pkg;
  typedef enum logic [1:0] {
    PS_HDR  = 2'd0,
    PS_FWD  = 2'd1,
    PS_CFG  = 2'd2,
    PS_DONE = 2'd3
  } pstate_t;
endpackage

// File: rtl/stem_field_shift.sv
module stem_field_shift #(
  parameter int W     = 15,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             clear,
  input  logic             bit_in,
  output logic [W-1:0]     word_next,
  output logic [CNT_W-1:0] cnt
);
  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;

  // MSB-first accumulation: the current bit lands in the LSB
  assign word_next = {sh_q[W-2:0], bit_in};
  assign cnt       = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (shift_en) sh_q <= word_next;
      if (clear)
        cnt_q <= '0;
      else if (shift_en)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: field position never runs past the longest field
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(W));
endmodule

// File: rtl/stem_fwd_gate.sv
module stem_fwd_gate (
  input  logic active,
  input  logic in_valid,
  input  logic in_bit,
  input  logic fwd_ready,
  input  logic nbr_done,
  output logic fwd_valid,
  output logic fwd_bit,
  output logic pass_ready
);
  logic open_path;
  assign open_path  = active && !nbr_done;
  assign fwd_valid  = open_path && in_valid;
  assign fwd_bit    = active ? in_bit : 1'b0;
  assign pass_ready = open_path && fwd_ready;
endmodule

// File: rtl/stem_cfg_reg.sv
module stem_cfg_reg #(
  parameter int TYPE_W = 3,
  parameter int DIR_W  = 3,
  parameter int NFACE  = 6,
  localparam int REC_W = TYPE_W + 2*DIR_W + NFACE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [REC_W-1:0]  rec,
  output logic              cfg_valid,
  output logic [TYPE_W-1:0] cfg_type,
  output logic [DIR_W-1:0]  cfg_in_a,
  output logic [DIR_W-1:0]  cfg_in_b,
  output logic [NFACE-1:0]  cfg_out_mask
);
  localparam int MASK_LO = 0;
  localparam int INB_LO  = NFACE;
  localparam int INA_LO  = NFACE + DIR_W;
  localparam int TYPE_LO = NFACE + 2*DIR_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_valid <= 1'b0;
      cfg_type  <= '0;
      cfg_in_a  <= '0;
      cfg_in_b  <= '0;
    end else if (commit) begin
      cfg_valid <= 1'b1;
      cfg_type  <= rec[TYPE_LO +: TYPE_W];
      cfg_in_a  <= rec[INA_LO +: DIR_W];
      cfg_in_b  <= rec[INB_LO +: DIR_W];
    end
  end

  for (genvar g = 0; g < NFACE; g++) begin : g_face
    always_ff @(posedge clk) begin
      if (rst)         cfg_out_mask[g] <= 1'b0;
      else if (commit) cfg_out_mask[g] <= rec[MASK_LO + g];
    end
  end

  // R5: the configuration moves only on a full-record commit
  p_cfg_atomic_r5: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable({cfg_valid, cfg_type, cfg_in_a, cfg_in_b, cfg_out_mask}));
endmodule

// File: rtl/stem_cfg_parser.sv
module stem_cfg_parser
  import stem_cfg_pkg::*;
#(
  parameter int DIR_W  = 3,
  parameter int TYPE_W = 3,
  parameter int NFACE  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              in_ready,
  output logic [DIR_W-1:0]  fwd_dir,
  output logic              fwd_valid,
  output logic              fwd_bit,
  input  logic              fwd_ready,
  input  logic              nbr_done,
  output logic              up_done,
  output logic              cfg_valid,
  output logic [TYPE_W-1:0] cfg_type,
  output logic [DIR_W-1:0]  cfg_in_a,
  output logic [DIR_W-1:0]  cfg_in_b,
  output logic [NFACE-1:0]  cfg_out_mask
);
  localparam int REC_W = TYPE_W + 2*DIR_W + NFACE;
  localparam int CNT_W = $clog2(REC_W + 1);
  localparam logic [DIR_W-1:0] LAST_FACE = DIR_W'(NFACE);
  localparam logic [CNT_W-1:0] HDR_END   = CNT_W'(DIR_W - 1);
  localparam logic [CNT_W-1:0] REC_END   = CNT_W'(REC_W - 1);

  pstate_t            st_q;
  logic [DIR_W-1:0]   dir_q;
  logic               done_q;
  logic [REC_W-1:0]   word_next;
  logic [CNT_W-1:0]   cnt;
  logic [DIR_W-1:0]   hdr_code;
  logic               parsing, take, shift_en, hdr_last, cfg_last;
  logic               pass_ready, fwd_active;

  assign fwd_active = (st_q == PS_FWD);
  assign parsing    = (st_q == PS_HDR) || (st_q == PS_CFG);
  assign in_ready   = parsing || pass_ready;
  assign take       = in_valid && in_ready;
  assign shift_en   = take && parsing;
  assign hdr_last   = take && (st_q == PS_HDR) && (cnt == HDR_END);
  assign cfg_last   = take && (st_q == PS_CFG) && (cnt == REC_END);
  assign hdr_code   = word_next[DIR_W-1:0];

  stem_field_shift #(.W(REC_W), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (shift_en),
    .clear     (hdr_last || cfg_last),
    .bit_in    (in_bit),
    .word_next (word_next),
    .cnt       (cnt)
  );

  stem_fwd_gate u_gate (
    .active     (fwd_active),
    .in_valid   (in_valid),
    .in_bit     (in_bit),
    .fwd_ready  (fwd_ready),
    .nbr_done   (nbr_done),
    .fwd_valid  (fwd_valid),
    .fwd_bit    (fwd_bit),
    .pass_ready (pass_ready)
  );

  stem_cfg_reg #(.TYPE_W(TYPE_W), .DIR_W(DIR_W), .NFACE(NFACE)) u_cfg (
    .clk          (clk),
    .rst          (rst),
    .commit       (cfg_last),
    .rec          (word_next),
    .cfg_valid    (cfg_valid),
    .cfg_type     (cfg_type),
    .cfg_in_a     (cfg_in_a),
    .cfg_in_b     (cfg_in_b),
    .cfg_out_mask (cfg_out_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PS_HDR;
      dir_q  <= '0;
      done_q <= 1'b0;
    end else begin
      unique case (st_q)
        PS_HDR: if (hdr_last) begin
          if (hdr_code == '0) begin
            st_q   <= PS_DONE;
            done_q <= 1'b1;
          end else if (hdr_code <= LAST_FACE) begin
            st_q  <= PS_FWD;
            dir_q <= hdr_code;
          end else begin
            st_q <= PS_CFG;
          end
        end
        PS_FWD: if (nbr_done) begin
          st_q  <= PS_HDR;
          dir_q <= '0;
        end
        PS_CFG:  if (cfg_last) st_q <= PS_HDR;
        PS_DONE: st_q <= PS_DONE;
        default: st_q <= PS_HDR;
      endcase
    end
  end

  assign fwd_dir = dir_q;
  assign up_done = done_q;

  // R6: done is sticky and closes the input
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    up_done |=> up_done);
  p_done_closed_r6: assert property (@(posedge clk) disable iff (rst)
    up_done |-> !in_ready);
  // R2: a forwarded bit always has a selected face
  p_fwd_has_dir_r2: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> (fwd_dir != '0) && (fwd_dir <= LAST_FACE));
  // R3: a bit the neighbour takes is also taken from upstream
  p_no_drop_r3: assert property (@(posedge clk) disable iff (rst)
    fwd_valid && fwd_ready |-> in_ready);
  // R4: the done cycle moves nothing and releases the face
  p_done_gap_r4: assert property (@(posedge clk) disable iff (rst)
    nbr_done && (fwd_dir != '0) |-> !in_ready && !fwd_valid);
  p_done_release_r4: assert property (@(posedge clk) disable iff (rst)
    nbr_done && (fwd_dir != '0) |=> (fwd_dir == '0));
  // R7: no input, no progress
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid && !nbr_done |=> $stable(st_q) && $stable(cnt));
endmodule

// File: tb/stem_cfg_parser_tb.sv
module stem_cfg_parser_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, in_valid, in_bit, in_ready, fwd_valid, fwd_bit, fwd_ready, nbr_done;
  logic up_done, cfg_valid;
  logic [2:0] fwd_dir, cfg_type, cfg_in_a, cfg_in_b;
  logic [5:0] cfg_out_mask;

  stem_cfg_parser u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .fwd_dir(fwd_dir), .fwd_valid(fwd_valid), .fwd_bit(fwd_bit), .fwd_ready(fwd_ready),
    .nbr_done(nbr_done), .up_done(up_done), .cfg_valid(cfg_valid), .cfg_type(cfg_type),
    .cfg_in_a(cfg_in_a), .cfg_in_b(cfg_in_b), .cfg_out_mask(cfg_out_mask)
  );

  int vectors = 0, errs = 0;
  bit stream[$];
  int targets[$];

  // behavioural model state
  int mst, mcnt, macc, mdir, mdone, mcv, mtype, ma, mb, mmask, fcount, ftarget;

  task automatic chk(input string tag, input int act, input int exp);
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_val(input int v, input int w);
    for (int i = w - 1; i >= 0; i--) stream.push_back(bit'((v >> i) & 1));
  endtask

  task automatic add_fwd(input int dir, input int len, input int pat);
    push_val(dir, 3);
    for (int i = 0; i < len; i++) stream.push_back(bit'((pat >> (i % 16)) & 1));
    targets.push_back(len);
  endtask

  task automatic add_cfg(input int t, input int a, input int b, input int m);
    push_val(7, 3);
    push_val(t, 3); push_val(a, 3); push_val(b, 3); push_val(m, 6);
  endtask

  task automatic model_reset();
    mst = 0; mcnt = 0; macc = 0; mdir = 0; mdone = 0; mcv = 0;
    mtype = 0; ma = 0; mb = 0; mmask = 0; fcount = 0; ftarget = 0;
  endtask

  task automatic run_pass(input int vprob, input int rprob, input int spur);
    int after_done;
    int cyc;
    int m_ready, m_fv;
    bit cur;
    rst = 1; in_valid = 0; in_bit = 0; fwd_ready = 0; nbr_done = 0;
    repeat (3) @(posedge clk);
    model_reset();
    @(negedge clk); rst = 0;
    after_done = 0; cyc = 0;
    while (after_done < 20) begin
      if (cyc > 5000) begin
        errs++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
        break;
      end
      // drive inputs away from the edge
      in_valid  = (stream.size() > 0) && ($urandom_range(0, 99) < vprob);
      cur       = (stream.size() > 0) ? stream[0] : 1'b0;
      in_bit    = in_valid ? cur : 1'b0;
      fwd_ready = ($urandom_range(0, 99) < rprob);
      if (mst == 1) nbr_done = (fcount == ftarget);
      else nbr_done = ($urandom_range(0, 99) < spur); // R8: stray done outside forwarding
      #1;
      m_ready = (mst == 0 || mst == 2) ? 1 : (mst == 1) ? int'(fwd_ready && !nbr_done) : 0;
      m_fv    = (mst == 1 && in_valid && !nbr_done) ? 1 : 0;
      vectors++;
      chk("R1/R4/R6/R7 in_ready", int'(in_ready), m_ready);
      chk("R3/R4 fwd_valid", int'(fwd_valid), m_fv);
      if (m_fv == 1) chk("R3 fwd_bit", int'(fwd_bit), int'(in_bit));
      chk("R2/R4/R8 fwd_dir", int'(fwd_dir), mdir);
      chk("R1/R6 up_done", int'(up_done), mdone);
      chk("R5/R9 cfg_valid", int'(cfg_valid), mcv);
      chk("R5/R9 cfg_type", int'(cfg_type), mtype);
      chk("R5/R9 cfg_in_a", int'(cfg_in_a), ma);
      chk("R5/R9 cfg_in_b", int'(cfg_in_b), mb);
      chk("R5/R9 cfg_out_mask", int'(cfg_out_mask), mmask);
      @(posedge clk);
      cyc++;
      // model update with the inputs held across this edge
      if (in_valid && m_ready == 1) begin
        void'(stream.pop_front());
        if (mst == 0) begin
          macc = macc * 2 + int'(cur); mcnt++;
          if (mcnt == 3) begin
            if (macc == 0) begin mst = 3; mdone = 1; end
            else if (macc <= 6) begin
              mst = 1; mdir = macc; fcount = 0;
              ftarget = (targets.size() > 0) ? targets.pop_front() : 0;
            end else mst = 2;
            mcnt = 0; macc = 0;
          end
        end else if (mst == 2) begin
          macc = macc * 2 + int'(cur); mcnt++;
          if (mcnt == 15) begin
            mtype = (macc >> 12) & 7; ma = (macc >> 9) & 7;
            mb = (macc >> 6) & 7; mmask = macc & 63; mcv = 1;
            mst = 0; mcnt = 0; macc = 0;
          end
        end else if (mst == 1) fcount++;
      end else if (mst == 1 && nbr_done) begin
        mst = 0; mdir = 0;
      end
      if (mdone == 1) after_done++;
      @(negedge clk);
    end
  endtask

  initial begin
    // pass 1: always valid and ready, so done collides with a live bit (R4)
    stream.delete(); targets.delete();
    add_fwd(3, 9, 16'hA5C3);
    add_cfg(5, 2, 4, 6'b101101);
    add_fwd(6, 0, 0);
    add_cfg(2, 6, 1, 6'b010010);        // R9 overwrite
    add_fwd(1, 20, 16'h3C96);
    push_val(0, 3);                      // R6 end code
    push_val(16'hFFFF, 12);              // junk after done, ignored
    run_pass(100, 100, 0);
    // pass 2: throttled input and neighbour, stray done pulses (R7, R8)
    stream.delete(); targets.delete();
    add_cfg(7, 7, 7, 6'b111111);
    add_fwd(4, 13, 16'h5A0F);
    add_cfg(1, 3, 5, 6'b000001);
    add_fwd(2, 5, 16'h0013);
    add_fwd(5, 31, 16'hBEEF);
    add_cfg(0, 0, 0, 6'b100000);
    push_val(0, 3);
    push_val(16'hAAAA, 10);
    run_pass(60, 55, 25);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule